// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Combiner

This block sits behind a three-stage pipelined analog-to-digital converter and turns the coarse codes of the stages into one binary sample word. The stages work on successive samples at the same time. For any one sample, the first stage's code appears in one clock cycle, the second stage's code one cycle later, and the third stage's code one cycle after that. The combiner holds the earlier codes in short delay lines until all three codes of a sample are present. It then forms the weighted sum and registers it as the output word. The result is one word per clock at full rate.

The first two stages carry one bit of redundancy. Each delivers a 3-bit code but resolves only 2 effective bits, so adjacent code fields overlap by one bit position. Because of that overlap, the words cannot be built by placing the codes side by side. A real addition is needed, and a carry out of a lower field must ripple into the fields above it. A sum that does not fit the 6-bit word clamps to all ones. When the parameters select stages without redundancy (raw width equal to effective width), a generate branch replaces the adder with plain concatenation, most significant stage first.

Top module: `pipe_code_merge`

## Requirements
- R1: A stage-1 code sampled at clock edge k is combined with the stage-2 code sampled at edge k+1 and the stage-3 code sampled at edge k+2. The word and its valid flag appear after edge k+2, so they are visible one cycle after the stage-3 code was presented.
- R2: The word is the sum of the stage-1 code shifted left by 3, the stage-2 code shifted left by 1, and the stage-3 code unshifted. Codes 001, 111 and 10 give 011000, and codes 0, 0, 0 give 000000.
- R3: A sum above 63 makes the word 111111. A sum of exactly 63 (for example 6, 7, 1) passes unchanged.
- R4: The word valid flag rises only for a sample whose three codes were all flagged valid in their own cycles. A sample missing any of its three valid flags produces no word and leaves the samples before and after it intact.
- R5: Back-to-back samples, one started every clock, produce one word every clock in the same order.
- R6: While the word valid flag is low, the word keeps its last value. Codes presented with their valid flag low have no effect on the word.
- R7: While the active-low reset is sampled low, the delay registers clear, the word becomes 000000 and the valid flag drops. Samples in flight at reset produce no word afterwards.
- R8: A carry out of a lower field ripples into the higher bits. For example, codes 0, 011 and 11 give 001001, and codes 1, 111 and 11 give 011001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| c1_raw | input | 3 | Raw code of stage 1 (redundant) |
| c1_vld | input | 1 | Stage-1 code valid in this cycle |
| c2_raw | input | 3 | Raw code of stage 2 (redundant), one cycle behind stage 1 |
| c2_vld | input | 1 | Stage-2 code valid in this cycle |
| c3_raw | input | 2 | Raw code of stage 3, two cycles behind stage 1 |
| c3_vld | input | 1 | Stage-3 code valid in this cycle |
| word | output | 6 | Combined, saturated output sample |
| word_vld | output | 1 | Word holds a new sample in this cycle |

## Verification
The hardest situation to reach is a partial sample. In that case one stage's valid flag is missing while the cycles on both sides carry complete samples, so that codes from three different samples share the delay lines. The driver keeps a per-sample valid mask and skews each sample's three codes across three cycles itself. It interleaves full and partial masks, both in directed sequences and in a long random stream. It also resets the block while two samples are half-way through the delay lines. Carry ripple and the clamp boundary are reached with directed code triples around the sum 63.

// File: rtl/pcm_pkg.sv
// Package: shared constants and field-offset arithmetic for the stage-code
// combiner. Assumes the last stage has no redundancy and that every
// redundant stage overlaps its lower neighbour by raw_w - eff_w bits.
package pcm_pkg;

    // Arrival skew of each stage's code relative to the last stage.
    localparam int STAGE1_LAG = 2;
    localparam int STAGE2_LAG = 1;

    // Bit position of the LSB of the stage-2 field in the output word.
    function automatic int off_stage2(int raw_w, int eff_w, int last_w);
        return last_w - (raw_w - eff_w);
    endfunction

    // Bit position of the LSB of the stage-1 field in the output word.
    function automatic int off_stage1(int raw_w, int eff_w, int last_w);
        return off_stage2(raw_w, eff_w, last_w) + eff_w;
    endfunction

    // Width of the combined output word.
    function automatic int word_width(int raw_w, int eff_w, int last_w);
        return off_stage1(raw_w, eff_w, last_w) + raw_w;
    endfunction

endpackage

// File: rtl/code_delay.sv
// Module: code_delay
// Fixed-depth delay line for one stage code and its valid flag. It lines
// up an early stage with the last stage of the same sample. Assumes a
// synchronous active-low reset. A depth of zero turns it into wires.
module code_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         dv,
    output logic [W-1:0] q,
    output logic         qv
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q  = d;
            assign qv = dv;
        end else begin : g_chain
            logic [W-1:0]     code_r [DEPTH];
            logic [DEPTH-1:0] vld_r;

            // Shift code and valid one slot per clock; reset clears all slots.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) code_r[i] <= '0;
                    vld_r <= '0;
                end else begin
                    code_r[0] <= d;
                    vld_r[0]  <= dv;
                    for (int i = 1; i < DEPTH; i++) begin
                        code_r[i] <= code_r[i-1];
                        vld_r[i]  <= vld_r[i-1];
                    end
                end
            end

            assign q  = code_r[DEPTH-1];
            assign qv = vld_r[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/weight_combine.sv
// Module: weight_combine
// Combinational shift-and-add of three aligned stage codes with a clamp to
// all ones on overflow. When the stages carry no redundancy
// (RAW_W == EFF_W), the fields do not overlap and the sum reduces to a
// concatenation. Assumes unsigned codes, so the result is never negative.
module weight_combine #(
    parameter int RAW_W  = 3,
    parameter int EFF_W  = 2,
    parameter int LAST_W = 2,
    parameter int OFF1   = 3,
    parameter int OFF2   = 1,
    parameter int OUT_W  = 6
) (
    input  logic [RAW_W-1:0]  a,
    input  logic [RAW_W-1:0]  b,
    input  logic [LAST_W-1:0] c,
    output logic [OUT_W-1:0]  y
);

    localparam int SUM_W = OUT_W + 2;

    generate
        if (RAW_W == EFF_W) begin : g_concat
            assign y = {a, b, c};
        end else begin : g_adder
            logic [SUM_W-1:0] t1, t2, t3, tot;
            logic             over;

            // Place each field at its weight and sum with full carry ripple.
            always_comb begin
                t1   = {{(SUM_W-RAW_W){1'b0}}, a} << OFF1;
                t2   = {{(SUM_W-RAW_W){1'b0}}, b} << OFF2;
                t3   = {{(SUM_W-LAST_W){1'b0}}, c};
                tot  = t1 + t2 + t3;
                over = |tot[SUM_W-1:OUT_W];
            end

            // Clamp to the largest word when the sum spills past OUT_W bits.
            always_comb begin
                y = over ? {OUT_W{1'b1}} : tot[OUT_W-1:0];
                AST_LSB_FLOOR: assert (y >= {{(OUT_W-LAST_W){1'b0}}, c}) else $error("AST_LSB_FLOOR"); // R3
            end
        end
    endgenerate

endmodule

// File: rtl/pipe_code_merge.sv
// Module: pipe_code_merge (top)
// Aligns the skewed codes of a three-stage pipelined converter and
// registers their weighted, saturated sum as one word per clock.
// Assumes stage k's code for a sample arrives k-1 cycles after stage 1's
// code, and a synchronous active-low reset.
module pipe_code_merge
    import pcm_pkg::*;
#(
    parameter int RAW_W  = 3,
    parameter int EFF_W  = 2,
    parameter int LAST_W = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [RAW_W-1:0]                            c1_raw,
    input  logic                                        c1_vld,
    input  logic [RAW_W-1:0]                            c2_raw,
    input  logic                                        c2_vld,
    input  logic [LAST_W-1:0]                           c3_raw,
    input  logic                                        c3_vld,
    output logic [word_width(RAW_W,EFF_W,LAST_W)-1:0]   word,
    output logic                                        word_vld
);

    localparam int OFF2  = off_stage2(RAW_W, EFF_W, LAST_W);
    localparam int OFF1  = off_stage1(RAW_W, EFF_W, LAST_W);
    localparam int OUT_W = word_width(RAW_W, EFF_W, LAST_W);
    localparam int CHK_W = OUT_W + 2;

    logic [RAW_W-1:0] d1_code, d2_code;
    logic             d1_vld, d2_vld;
    logic [OUT_W-1:0] sum_word;
    logic             all_vld;

    code_delay #(.W(RAW_W), .DEPTH(STAGE1_LAG)) u_dly1 (
        .clk(clk), .rst_n(rst_n), .d(c1_raw), .dv(c1_vld), .q(d1_code), .qv(d1_vld)
    );

    code_delay #(.W(RAW_W), .DEPTH(STAGE2_LAG)) u_dly2 (
        .clk(clk), .rst_n(rst_n), .d(c2_raw), .dv(c2_vld), .q(d2_code), .qv(d2_vld)
    );

    weight_combine #(
        .RAW_W(RAW_W), .EFF_W(EFF_W), .LAST_W(LAST_W),
        .OFF1(OFF1), .OFF2(OFF2), .OUT_W(OUT_W)
    ) u_comb (
        .a(d1_code), .b(d2_code), .c(c3_raw), .y(sum_word)
    );

    assign all_vld = d1_vld & d2_vld & c3_vld;

    // Register the combined word when a complete sample is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= all_vld;
            if (all_vld) word <= sum_word;
        end
    end

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ($past(c3_vld) && $past(c2_vld, 2) && $past(c1_vld, 3))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!word_vld && word == '0)); // R7

    AST_MSB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ({{(CHK_W-OUT_W){1'b0}}, word} >=
                      ({{(CHK_W-RAW_W){1'b0}}, $past(c1_raw, 3)} << OFF1))); // R2

endmodule

// File: tb/test_pipe_code_merge.sv
// Scoreboard bench: the driver skews each sample's codes across three
// cycles and queues the expected word; the monitor pops and compares.
module test_pipe_code_merge;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] c1_raw = '0, c2_raw = '0;
    logic [1:0] c3_raw = '0;
    logic       c1_vld = 1'b0, c2_vld = 1'b0, c3_vld = 1'b0;
    logic [5:0] word;
    logic       word_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_code_merge i_pipe_code_merge (
        .clk(clk), .rst_n(rst_n),
        .c1_raw(c1_raw), .c1_vld(c1_vld),
        .c2_raw(c2_raw), .c2_vld(c2_vld),
        .c3_raw(c3_raw), .c3_vld(c3_vld),
        .word(word), .word_vld(word_vld)
    );

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    logic [5:0] last_word = '0;

    logic [5:0] q_word[$];
    int         q_due[$];
    string      q_tag[$];

    // Sample history, index 0 = newest; mask bit i = stage i+1 valid.
    logic [2:0] h_c1[3], h_c2[3], h_m[3];
    logic [1:0] h_c3[3];
    string      h_tag[3];

    always @(posedge clk) cyc++;

    // Expected word from R2/R3: a<<3 + b<<1 + c, clamped to 63.
    function automatic logic [5:0] ref_merge(logic [2:0] a, logic [2:0] b, logic [1:0] c);
        int s;
        s = int'(a) * 8 + int'(b) * 2 + int'(c);
        return (s > 63) ? 6'd63 : 6'(s);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] m, input logic [2:0] a, input logic [2:0] b,
                        input logic [1:0] c, input string tag);
        @(negedge clk);
        for (int i = 2; i > 0; i--) begin
            h_c1[i] = h_c1[i-1]; h_c2[i] = h_c2[i-1]; h_c3[i] = h_c3[i-1];
            h_m[i] = h_m[i-1]; h_tag[i] = h_tag[i-1];
        end
        h_c1[0] = a; h_c2[0] = b; h_c3[0] = c; h_m[0] = m; h_tag[0] = tag;
        c1_raw = h_c1[0]; c1_vld = h_m[0][0];
        c2_raw = h_c2[1]; c2_vld = h_m[1][1];
        c3_raw = h_c3[2]; c3_vld = h_m[2][2];
        if (h_m[2] == 3'b111) begin
            q_word.push_back(ref_merge(h_c1[2], h_c2[2], h_c3[2]));
            q_due.push_back(cyc + 1);
            q_tag.push_back(h_tag[2]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        c1_vld = 1'b0; c2_vld = 1'b0; c3_vld = 1'b0;
        for (int i = 0; i < 3; i++) begin
            h_m[i] = '0; h_c1[i] = '0; h_c2[i] = '0; h_c3[i] = '0; h_tag[i] = "";
        end
        repeat (3) @(negedge clk);
        q_word.delete(); q_due.delete(); q_tag.delete();
        last_word = '0;
        rst_n = 1'b1;
    endtask

    // Monitor: compare each produced word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (word_vld) begin
                if (q_word.size() == 0) begin
                    check(1'b0, "R4 or R7", "unexpected word", int'(word), -1);
                end else begin
                    check(word == q_word[0], q_tag[0], "word", int'(word), int'(q_word[0]));
                    check(cyc == q_due[0], "R1", "output cycle", cyc, q_due[0]);
                    void'(q_word.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
                end
                last_word = word;
            end else begin
                check(word == last_word, "R6", "idle hold", int'(word), int'(last_word));
                if (q_due.size() != 0 && q_due[0] <= cyc) begin
                    check(1'b0, "R1", "missing word at cycle", cyc, q_due[0]);
                    void'(q_word.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            h_m[i] = '0; h_c1[i] = '0; h_c2[i] = '0; h_c3[i] = '0; h_tag[i] = "";
        end
        do_reset();
        @(negedge clk);
        check(word_vld == 1'b0, "R7", "valid after reset", int'(word_vld), 0);
        check(word == 6'd0, "R7", "word after reset", int'(word), 0);

        // R2 worked example and zero; R3 clamp boundary; R8 carry ripple.
        step(3'b111, 3'd1, 3'd7, 2'd2, "R2");
        step(3'b111, 3'd0, 3'd0, 2'd0, "R2");
        step(3'b111, 3'd7, 3'd7, 2'd3, "R3");
        step(3'b111, 3'd6, 3'd7, 2'd1, "R3");
        step(3'b111, 3'd7, 3'd3, 2'd3, "R3");
        step(3'b111, 3'd0, 3'd3, 2'd3, "R8");
        step(3'b111, 3'd1, 3'd7, 2'd3, "R8");
        repeat (3) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");

        // R5 back-to-back burst.
        for (int i = 0; i < 8; i++)
            step(3'b111, 3'(i), 3'(7 - i), 2'(i), "R5");
        repeat (3) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");

        // R4 partial samples between complete neighbours.
        step(3'b111, 3'd2, 3'd5, 2'd1, "R4");
        step(3'b101, 3'd5, 3'd5, 2'd1, "R4");
        step(3'b111, 3'd3, 3'd1, 2'd2, "R4");
        step(3'b011, 3'd7, 3'd7, 2'd3, "R4");
        step(3'b110, 3'd7, 3'd7, 2'd3, "R4");
        step(3'b111, 3'd4, 3'd2, 2'd0, "R4");
        repeat (3) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");

        // R6 codes with valid low are ignored.
        repeat (5) step(3'b000, 3'd7, 3'd7, 2'd3, "R6");
        repeat (3) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");

        // Random stream with mostly complete samples.
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] m;
            m = ($urandom_range(0, 99) < 85) ? 3'b111 : 3'($urandom_range(0, 7));
            step(m, 3'($urandom), 3'($urandom), 2'($urandom), "R2");
        end
        repeat (3) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");

        // R7 reset with samples in flight; none may emerge.
        step(3'b111, 3'd5, 3'd5, 2'd2, "R7");
        step(3'b111, 3'd6, 3'd1, 2'd1, "R7");
        do_reset();
        @(negedge clk);
        check(word == 6'd0, "R7", "word after mid reset", int'(word), 0);
        repeat (4) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");
        step(3'b111, 3'd1, 3'd7, 2'd2, "R7");
        repeat (3) step(3'b000, 3'd0, 3'd0, 2'd0, "idle");

        @(negedge clk);
        check(q_word.size() == 0, "R5", "words left unmatched", q_word.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule